// File: doc/BRIEF.md
# General-Purpose I/O Port Register Bank

This block holds the configuration and output state of a 50-pin general-purpose I/O port and presents it to software through a 16-bit register bus. Pins 0 to 31 are bidirectional, each with its own direction bit and data bit. Pins 32 to 47 are output-only data pins. Pins 48 and 49 are outputs whose drivers are switched on by two enable bits that share a register with their data. The first fifteen pins also have a pull resistor, controlled by an enable register and a polarity register.

Each access is a single request carrying an offset, a write flag, write data and a per-bit write mask. The mask lets software change a few bits of a register without a separate read. A small sequencer has two states:

- **IDLE** accepts the request. Transition *accept*: IDLE to ACK when `bus_req` is high.
- **ACK** returns the acknowledge and the read data. Transition *release*: ACK to IDLE, unconditionally.

Pad inputs of the bidirectional pins pass through a synchronizer before anything reads them. The pad-facing outputs follow the stored registers directly.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the direction bits, the pin 48/49 enables, the pull enables and all output latches are 0. `pad_oe[31:0]`, `pad_oe[49:48]`, `pad_out`, `pad_pu` and `pad_pd` are all 0. `pad_oe[47:32]` is all ones.
- R2: The direction registers are at offset 0x000 (pins 0 to 15, bit n is pin n) and 0x002 (pins 16 to 31, bit n is pin 16+n). A bit value of 1 sets `pad_oe` for that pin, and the value reads back unchanged.
- R3: The data registers are at offset 0x004 (pins 0 to 15) and 0x006 (pins 16 to 31). A write sets the output latch, which drives `pad_out`. On a read, a pin whose direction bit is 1 returns its latch. A pin whose direction bit is 0 returns its pad level, once the level has been stable for three clock cycles.
- R4: Offset 0x01C holds the output data of pins 32 to 47 (bit n is pin 32+n). It drives `pad_out[47:32]` and reads back the latch.
- R5: In offset 0x01E, bits 0 and 1 are the data of pins 48 and 49, and bits 8 and 9 are their output enables (`pad_oe[48]` and `pad_oe[49]`). All other bits read as 0 and store nothing.
- R6: Offset 0x1E0 holds the pull enables and offset 0x1E2 the pull polarities of pins 0 to 14 (bit n is pin n). A polarity bit of 1 selects pull-up and 0 selects pull-down. `pad_pu[n]` is enable AND polarity, and `pad_pd[n]` is enable AND NOT polarity, so a cleared enable leaves both low. Bit 15 of both registers reads 0.
- R7: A write changes only the bits whose `bus_wmask` bit is 1. All other bits keep their value.
- R8: A read of any other offset returns 0. A write to any other offset changes no output and no register.
- R9: In IDLE, a request is accepted on a clock edge. `bus_ack` is high for exactly the following cycle, with `bus_rdata` valid. A request that is still held during ACK is ignored.
- R10: A write takes effect on `pad_out` and `pad_oe` at the same edge that accepts it. A single write to 0x01E therefore enables pin 48 and sets its data together, and a data write issued before a direction write means the pad is already holding the new value when it starts to drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_wmask | input | 16 | Per-bit write mask (1 = update) |
| bus_ack | output | 1 | Access completed; read data valid |
| bus_rdata | output | 16 | Read data |
| pad_in | input | 32 | Pad levels of pins 0 to 31 |
| pad_out | output | 50 | Output value per pin |
| pad_oe | output | 50 | Driver enable per pin |
| pad_pu | output | 15 | Pull-up on, pins 0 to 14 |
| pad_pd | output | 15 | Pull-down on, pins 0 to 14 |

## Verification
A single write to 0x01E updates a data bit and an output enable of the same pin on the same edge. The bench issues one such write and checks `pad_out[48]` and `pad_oe[48]` together right after acceptance, so a driver that turns on ahead of its data would show up. A data read can also meet a pad change and a direction change in the same cycle. To judge it, the bench sets a mixed direction pattern, holds pad levels that differ from the latches, and expects each bit of the read to come from the latch or the pad according to its direction bit.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 16;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } bus_state_t;

    localparam logic [ADDR_W-1:0] OFS_DIR_LO  = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_DIR_HI  = 10'h002;
    localparam logic [ADDR_W-1:0] OFS_DAT_LO  = 10'h004;
    localparam logic [ADDR_W-1:0] OFS_DAT_HI  = 10'h006;
    localparam logic [ADDR_W-1:0] OFS_MID     = 10'h01C;
    localparam logic [ADDR_W-1:0] OFS_TOP     = 10'h01E;
    localparam logic [ADDR_W-1:0] OFS_PULL_EN = 10'h1E0;
    localparam logic [ADDR_W-1:0] OFS_PULL_UP = 10'h1E2;

    // bit positions inside the pin 48/49 register
    localparam int TOP_DAT_LSB = 0;
    localparam int TOP_OEN_LSB = 8;

    function automatic logic [DATA_W-1:0] masked_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [DATA_W-1:0] msk
    );
        return (old_v & ~msk) | (new_v & msk);
    endfunction

endpackage

// File: rtl/gpio_rb_sync.sv
module gpio_rb_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_rb_regs.sv
module gpio_rb_regs
    import gpio_rb_pkg::*;
#(
    parameter int NUM_BIDIR = 32,
    parameter int NUM_MID   = 16,
    parameter int NUM_PULL  = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_fire,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W-1:0]    wmask,
    output logic [NUM_BIDIR-1:0] dir_q,
    output logic [NUM_BIDIR-1:0] dat_q,
    output logic [NUM_MID-1:0]   mid_q,
    output logic [1:0]           top_dat_q,
    output logic [1:0]           top_oen_q,
    output logic [NUM_PULL-1:0]  pull_en_q,
    output logic [NUM_PULL-1:0]  pull_pol_q
);

    localparam int HALF     = NUM_BIDIR / 2;
    localparam int PULL_PAD = DATA_W - NUM_PULL;

    logic [DATA_W-1:0] dir_lo_w, dir_hi_w, dat_lo_w, dat_hi_w, mid_w;
    logic [DATA_W-1:0] top_w, pen_w, ppol_w, top_old;

    always_comb begin
        top_old = '0;
        top_old[TOP_DAT_LSB +: 2] = top_dat_q;
        top_old[TOP_OEN_LSB +: 2] = top_oen_q;
        dir_lo_w = masked_merge(dir_q[HALF-1:0], wdata, wmask);
        dir_hi_w = masked_merge(dir_q[NUM_BIDIR-1:HALF], wdata, wmask);
        dat_lo_w = masked_merge(dat_q[HALF-1:0], wdata, wmask);
        dat_hi_w = masked_merge(dat_q[NUM_BIDIR-1:HALF], wdata, wmask);
        mid_w    = masked_merge(mid_q, wdata, wmask);
        top_w    = masked_merge(top_old, wdata, wmask);
        pen_w    = masked_merge({{PULL_PAD{1'b0}}, pull_en_q}, wdata, wmask);
        ppol_w   = masked_merge({{PULL_PAD{1'b0}}, pull_pol_q}, wdata, wmask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q      <= '0;
            dat_q      <= '0;
            mid_q      <= '0;
            top_dat_q  <= '0;
            top_oen_q  <= '0;
            pull_en_q  <= '0;
            pull_pol_q <= '0;
        end else if (wr_fire) begin
            unique case (addr)
                OFS_DIR_LO:  dir_q[HALF-1:0]         <= dir_lo_w;
                OFS_DIR_HI:  dir_q[NUM_BIDIR-1:HALF] <= dir_hi_w;
                OFS_DAT_LO:  dat_q[HALF-1:0]         <= dat_lo_w;
                OFS_DAT_HI:  dat_q[NUM_BIDIR-1:HALF] <= dat_hi_w;
                OFS_MID:     mid_q                   <= mid_w;
                OFS_TOP: begin
                    top_dat_q <= top_w[TOP_DAT_LSB +: 2];
                    top_oen_q <= top_w[TOP_OEN_LSB +: 2];
                end
                OFS_PULL_EN: pull_en_q  <= pen_w[NUM_PULL-1:0];
                OFS_PULL_UP: pull_pol_q <= ppol_w[NUM_PULL-1:0];
                default: ;
            endcase
        end
    end

    // direction bits only move on a write to their own offset
    AST_DIR_LO_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_q[HALF-1:0]) |-> $past(wr_fire && addr == OFS_DIR_LO)); // R2

    AST_PULL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pull_en_q) |-> $past(wr_fire && addr == OFS_PULL_EN)); // R6

endmodule

// File: rtl/gpio_rb_rdmux.sv
module gpio_rb_rdmux
    import gpio_rb_pkg::*;
#(
    parameter int NUM_BIDIR = 32,
    parameter int NUM_MID   = 16,
    parameter int NUM_PULL  = 15
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_BIDIR-1:0] dir_q,
    input  logic [NUM_BIDIR-1:0] dat_q,
    input  logic [NUM_BIDIR-1:0] pad_sync,
    input  logic [NUM_MID-1:0]   mid_q,
    input  logic [1:0]           top_dat_q,
    input  logic [1:0]           top_oen_q,
    input  logic [NUM_PULL-1:0]  pull_en_q,
    input  logic [NUM_PULL-1:0]  pull_pol_q,
    output logic [DATA_W-1:0]    rdata,
    output logic                 hit
);

    localparam int HALF     = NUM_BIDIR / 2;
    localparam int PULL_PAD = DATA_W - NUM_PULL;

    logic [NUM_BIDIR-1:0] pin_view;

    generate
        for (genvar i = 0; i < NUM_BIDIR; i++) begin : g_view
            assign pin_view[i] = dir_q[i] ? dat_q[i] : pad_sync[i];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        hit   = 1'b1;
        unique case (addr)
            OFS_DIR_LO:  rdata = dir_q[HALF-1:0];
            OFS_DIR_HI:  rdata = dir_q[NUM_BIDIR-1:HALF];
            OFS_DAT_LO:  rdata = pin_view[HALF-1:0];
            OFS_DAT_HI:  rdata = pin_view[NUM_BIDIR-1:HALF];
            OFS_MID:     rdata = mid_q;
            OFS_TOP: begin
                rdata[TOP_DAT_LSB +: 2] = top_dat_q;
                rdata[TOP_OEN_LSB +: 2] = top_oen_q;
            end
            OFS_PULL_EN: rdata = {{PULL_PAD{1'b0}}, pull_en_q};
            OFS_PULL_UP: rdata = {{PULL_PAD{1'b0}}, pull_pol_q};
            default:     hit   = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_rb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_PULL    = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_wmask,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [31:0]       pad_in,
    output logic [49:0]       pad_out,
    output logic [49:0]       pad_oe,
    output logic [NUM_PULL-1:0] pad_pu,
    output logic [NUM_PULL-1:0] pad_pd
);

    localparam int NUM_BIDIR = 32;
    localparam int NUM_MID   = 16;

    bus_state_t state_q, state_d;
    logic       accept, wr_fire, rd_fire, rd_hit;
    logic [DATA_W-1:0] rd_next, rdata_q;

    logic [NUM_BIDIR-1:0] dir_q, dat_q, pad_sync;
    logic [NUM_MID-1:0]   mid_q;
    logic [1:0]           top_dat_q, top_oen_q;
    logic [NUM_PULL-1:0]  pull_en_q, pull_pol_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: accept, then release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_req) state_d = ST_ACK;
            ST_ACK:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        accept  = 1'b0;
        bus_ack = 1'b0;
        unique case (state_q)
            ST_IDLE: accept  = bus_req;
            ST_ACK:  bus_ack = 1'b1;
            default: ;
        endcase
    end

    assign wr_fire = accept & bus_we;
    assign rd_fire = accept & ~bus_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_fire) rdata_q <= rd_next;
        else if (accept)  rdata_q <= '0;
    end
    assign bus_rdata = rdata_q;

    gpio_rb_sync #(.WIDTH(NUM_BIDIR), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (pad_sync)
    );

    gpio_rb_regs #(.NUM_BIDIR(NUM_BIDIR), .NUM_MID(NUM_MID), .NUM_PULL(NUM_PULL)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_fire    (wr_fire),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .wmask      (bus_wmask),
        .dir_q      (dir_q),
        .dat_q      (dat_q),
        .mid_q      (mid_q),
        .top_dat_q  (top_dat_q),
        .top_oen_q  (top_oen_q),
        .pull_en_q  (pull_en_q),
        .pull_pol_q (pull_pol_q)
    );

    gpio_rb_rdmux #(.NUM_BIDIR(NUM_BIDIR), .NUM_MID(NUM_MID), .NUM_PULL(NUM_PULL)) u_rdmux (
        .addr       (bus_addr),
        .dir_q      (dir_q),
        .dat_q      (dat_q),
        .pad_sync   (pad_sync),
        .mid_q      (mid_q),
        .top_dat_q  (top_dat_q),
        .top_oen_q  (top_oen_q),
        .pull_en_q  (pull_en_q),
        .pull_pol_q (pull_pol_q),
        .rdata      (rd_next),
        .hit        (rd_hit)
    );

    // pad-facing signals follow the stored state directly
    assign pad_out = {top_dat_q, mid_q, dat_q};
    assign pad_oe  = {top_oen_q, {NUM_MID{1'b1}}, dir_q};
    assign pad_pu  = pull_en_q & pull_pol_q;
    assign pad_pd  = pull_en_q & ~pull_pol_q;

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack); // R9

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_req)); // R9

    AST_TOP_OE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pad_oe[49:48]) |-> $past(wr_fire && bus_addr == OFS_TOP)); // R5

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && $past(rd_fire && !rd_hit)) |-> (bus_rdata == '0)); // R8

endmodule

// File: tb/tb_gpio_regbank.sv
module tb_gpio_regbank;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_wmask = '0;
    logic        bus_ack;
    logic [15:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [49:0] pad_out, pad_oe;
    logic [14:0] pad_pu, pad_pd;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_regbank dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wmask(bus_wmask),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // starts and ends at a negative edge
    task automatic bus_op(input logic we, input logic [9:0] a, input logic [15:0] wd,
                          input logic [15:0] wm, output logic [15:0] rd);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd; bus_wmask = wm;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0;
        chk("R9 ack after accept", {63'd0, bus_ack}, 64'd1);
        rd = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        chk("R9 ack drops", {63'd0, bus_ack}, 64'd0);
    endtask

    task automatic wr(input logic [9:0] a, input logic [15:0] wd, input logic [15:0] wm = 16'hFFFF);
        logic [15:0] unused_rd;
        bus_op(1'b1, a, wd, wm, unused_rd);
    endtask

    task automatic rd_chk(input string tag, input logic [9:0] a, input logic [15:0] exp);
        logic [15:0] v;
        bus_op(1'b0, a, 16'h0, 16'h0, v);
        chk(tag, {48'd0, v}, {48'd0, exp});
    endtask

    task automatic t_reset();
        chk("R1 pad_out", pad_out, 64'd0);
        chk("R1 pad_oe", pad_oe, {14'd0, 2'b00, 16'hFFFF, 32'h0});
        chk("R1 pad_pu", pad_pu, 64'd0);
        chk("R1 pad_pd", pad_pd, 64'd0);
        rd_chk("R1 dir lo", 10'h000, 16'h0000);
        rd_chk("R1 top reg", 10'h01E, 16'h0000);
    endtask

    task automatic t_dir_data();
        wr(10'h000, 16'h00FF);
        wr(10'h002, 16'hA5A5);
        chk("R2 oe 0..31", pad_oe[31:0], {32'd0, 32'hA5A5_00FF});
        rd_chk("R2 dir hi readback", 10'h002, 16'hA5A5);
        wr(10'h004, 16'h0055);
        chk("R3 pad_out lo", pad_out[15:0], 64'h0055);
        pad_in = 32'h1234_A3C0;
        repeat (3) @(negedge clk);
        rd_chk("R3 mixed latch/pad lo", 10'h004, 16'hA355);
        wr(10'h002, 16'h0000);
        rd_chk("R3 input view hi", 10'h006, 16'h1234);
        wr(10'h006, 16'hBEEF);
        wr(10'h002, 16'hFFFF);
        rd_chk("R3 output view hi", 10'h006, 16'hBEEF);
    endtask

    task automatic t_mid();
        wr(10'h01C, 16'hC3A1);
        chk("R4 pad_out 32..47", pad_out[47:32], 64'hC3A1);
        chk("R4 oe 32..47", pad_oe[47:32], 64'hFFFF);
        rd_chk("R4 readback", 10'h01C, 16'hC3A1);
    endtask

    task automatic t_top_order();
        // data written before direction: pad already holds it
        wr(10'h000, 16'h0000);
        wr(10'h004, 16'h0008);
        chk("R10 data before dir out", pad_out[3], 64'd1);
        chk("R10 data before dir oe", pad_oe[3], 64'd0);
        wr(10'h000, 16'h0008);
        chk("R10 dir on keeps value", {62'd0, pad_oe[3], pad_out[3]}, 64'd3);
        // one write sets both data and enable of pins 48/49
        wr(10'h01E, 16'hFFF1);
        chk("R10 pin48 out+oe same edge", {62'd0, pad_oe[48], pad_out[48]}, 64'd3);
        chk("R5 pin49", {62'd0, pad_oe[49], pad_out[49]}, 64'd2);
        rd_chk("R5 unused bits read 0", 10'h01E, 16'h0301);
        wr(10'h01E, 16'h0000, 16'h0100);
        chk("R5 pin48 oe off", {62'd0, pad_oe[49:48]}, 64'd2);
    endtask

    task automatic t_pull();
        wr(10'h1E0, 16'hFFFF);
        wr(10'h1E2, 16'h00F0);
        chk("R6 pull-up", pad_pu, 64'h00F0);
        chk("R6 pull-down", pad_pd, 64'h7F0F);
        rd_chk("R6 bit15 reads 0", 10'h1E0, 16'h7FFF);
        wr(10'h1E0, 16'h0000, 16'h0011);
        chk("R6 disabled up", pad_pu, 64'h00E0);
        chk("R6 disabled down", pad_pd, 64'h7F0E);
    endtask

    task automatic t_mask();
        wr(10'h006, 16'hFFFF);
        wr(10'h006, 16'h0000, 16'h00F0);
        chk("R7 masked data", pad_out[31:16], 64'hFF0F);
        wr(10'h01C, 16'h0000, 16'h0000);
        chk("R7 zero mask", pad_out[47:32], 64'hC3A1);
    endtask

    task automatic t_unmapped();
        logic [49:0] so, soe;
        logic [14:0] spu, spd;
        so = pad_out; soe = pad_oe; spu = pad_pu; spd = pad_pd;
        wr(10'h008, 16'hFFFF);
        wr(10'h1E4, 16'hFFFF);
        wr(10'h001, 16'hFFFF);
        chk("R8 pad_out kept", pad_out, so);
        chk("R8 pad_oe kept", pad_oe, soe);
        chk("R8 pulls kept", {pad_pu, pad_pd}, {spu, spd});
        rd_chk("R8 read 0x008", 10'h008, 16'h0000);
        rd_chk("R8 read 0x3FE", 10'h3FE, 16'h0000);
        rd_chk("R8 dir lo untouched", 10'h000, 16'h0008);
    endtask

    task automatic t_hold();
        // request held through ACK must not be taken twice
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 10'h004; bus_wdata = 16'h1111; bus_wmask = 16'hFFFF;
        @(posedge clk);
        @(negedge clk);
        chk("R9 ack held req", {63'd0, bus_ack}, 64'd1);
        bus_wdata = 16'h2222;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0;
        chk("R9 no ack in 2nd cycle", {63'd0, bus_ack}, 64'd0);
        chk("R9 second value ignored", pad_out[15:0], 64'h1111);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir_data();
        t_mid();
        t_top_order();
        t_pull();
        t_mask();
        t_unmapped();
        t_hold();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule